// File: doc/BRIEF.md
# CAN Error Flag and Interrupt Unit

This unit sits beside a CAN protocol engine and turns its error reporting into software-visible state. The engine delivers one-cycle pulses, one for each kind of controller event (bus lock, overload frame, receive overrun, bus-off recovery, bus-off entry, error passive, error warning) and one for each kind of protocol error (stuff, form, ACK, CRC, recessive bit, dominant bit, ACK delimiter). The unit latches these pulses into a flag byte and an error-code byte. Software clears them one bit at a time by writing zeros.

Each flag has an enable bit. The enabled flags are merged into one summary bit in an interrupt status byte, and a separate interrupt-enable bit gates that summary onto the interrupt line. The error-code byte has two modes. It can accumulate every code seen since the last clear, or it can hold only the codes of the most recent error. The transmit and receive error counters of the engine pass through to the same read port.

Top module: `canerr_irq_unit`

## Requirements
- R1: After reset the flag, flag-enable, error-code and interrupt-enable state are all zero, `irq_o` is low, and reads of selects 0 to 4 and 7 return 0.
- R2: A pulse on `flag_evt_i[k]` (k = 0..6) sets flag bit k+1. Bit 7 is bus lock, 6 overload frame, 5 receive overrun, 4 bus-off recovery, 3 bus-off entry, 2 error passive and 1 error warning. A flag stays set until software clears it.
- R3: A cycle with any bit of `code_evt_i` set also sets flag bit 0 (bus error).
- R4: A write to select 0 clears every flag bit written as 0 and leaves every flag bit written as 1 unchanged. It never sets a flag.
- R5: When an event and a clear write hit the same flag bit in the same cycle, the flag ends up set. The same rule holds for error-code bits.
- R6: When code bit 7 (mode) is 1, each code pulse ORs into code bits 6..0. Bit 6 is ACK delimiter, 5 dominant bit, 4 recessive bit, 3 CRC, 2 ACK, 1 form and 0 stuff.
- R7: When code bit 7 is 0, a cycle with a nonzero `code_evt_i` replaces code bits 6..0 with exactly that pulse vector. The mode used is the value held before any write in the same cycle.
- R8: A write to select 2 clears code bits 6..0 that are written as 0 and keeps those written as 1. Code bit 7 takes the written bit 7.
- R9: Status byte (select 3) bit 5 is 1 exactly when some flag bit and its enable bit (select 1, same layout as the flags) are both 1. All other status bits are 0.
- R10: `irq_o` is the status summary bit ANDed with interrupt-enable bit 5 (select 4). Select 4 reads back only bit 5; its other bits read 0.
- R11: Read select 5 returns `tx_err_cnt_i` and select 6 returns `rx_err_cnt_i`, both combinationally. Select 7 returns 0. Writes to selects 3, 5, 6 and 7 change nothing.
- R12: A write to select 1 loads the whole byte into the flag-enable register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_evt_i | input | 7 | One-cycle controller event pulses for flag bits 7..1 |
| code_evt_i | input | 7 | One-cycle protocol error pulses for code bits 6..0 |
| tx_err_cnt_i | input | 8 | Transmit error counter from the engine |
| rx_err_cnt_i | input | 8 | Receive error counter from the engine |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 3 | Register select for the read |
| rd_data_o | output | 8 | Combinational read data |
| flag_o | output | 8 | Current flag byte |
| code_o | output | 8 | Current error-code byte including the mode bit |
| irq_o | output | 1 | Gated error interrupt |

## Verification
The hardest case to reach from the ports is an event pulse arriving in the very cycle that software writes a clear to the same bit. The same applies to a replace-mode code pulse landing on a code clear write. The stimulus places the write strobe and the pulse on one clock edge, once on purpose and many more times through a pseudo-random phase that drives writes and pulses together. A behavioural byte model is compared with the flag, code and interrupt outputs on every cycle.

// File: rtl/canerr_pkg.sv
package canerr_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned NUM_CODES  = 7;
  localparam int unsigned NUM_EVTS   = 7;
  localparam int unsigned SUMMARY_B  = 5;
  localparam int unsigned SEL_W      = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_FLAG = 3'd0,
    SEL_ENA  = 3'd1,
    SEL_CODE = 3'd2,
    SEL_STAT = 3'd3,
    SEL_IE   = 3'd4,
    SEL_TEC  = 3'd5,
    SEL_REC  = 3'd6,
    SEL_NONE = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/canerr_flag_bank.sv
module canerr_flag_bank #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_wr_i,
  input  logic [WIDTH-1:0] clr_data_i,
  output logic [WIDTH-1:0] flag_o
);
  // One flop per flag, each with its own enable; set dominates clear.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic nxt, upd, q;
    always_comb begin
      upd = set_i[b] | (clr_wr_i & ~clr_data_i[b]);
      nxt = set_i[b];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (upd) q <= nxt;
    end
    assign flag_o[b] = q;
  end
endmodule

// File: rtl/canerr_code_store.sv
module canerr_code_store #(
  parameter int unsigned NCODE = canerr_pkg::NUM_CODES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCODE-1:0] evt_i,
  input  logic             wr_i,
  input  logic [NCODE:0]   wdata_i,
  output logic [NCODE:0]   code_o,
  output logic             any_evt_o
);
  logic [NCODE-1:0] code_q, code_nxt, kept;
  logic             mode_q, mode_nxt;
  logic             any_evt, upd;

  always_comb begin
    any_evt  = |evt_i;
    kept     = wr_i ? (code_q & wdata_i[NCODE-1:0]) : code_q;
    mode_nxt = wr_i ? wdata_i[NCODE] : mode_q;
    if (any_evt) code_nxt = mode_q ? (kept | evt_i) : evt_i;
    else         code_nxt = kept;
    upd      = wr_i | any_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mode_q <= 1'b0;
    end else if (upd) begin
      code_q <= code_nxt;
      mode_q <= mode_nxt;
    end
  end

  assign code_o    = {mode_q, code_q};
  assign any_evt_o = any_evt;
endmodule

// File: rtl/canerr_irq_merge.sv
module canerr_irq_merge
  import canerr_pkg::*;
#(
  parameter int unsigned W = BYTE_W
) (
  input  logic [W-1:0]     flag_i,
  input  logic [W-1:0]     ena_i,
  input  logic [W-1:0]     code_i,
  input  logic             ie_i,
  input  logic [W-1:0]     tec_i,
  input  logic [W-1:0]     rec_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [W-1:0]     rd_data_o,
  output logic             irq_o
);
  logic         summary;
  logic [W-1:0] stat_b, ie_b;

  always_comb begin
    summary = |(flag_i & ena_i);
    stat_b  = '0;
    stat_b[SUMMARY_B] = summary;
    ie_b    = '0;
    ie_b[SUMMARY_B] = ie_i;
    irq_o   = summary & ie_i;
    case (reg_sel_e'(rd_sel_i))
      SEL_FLAG: rd_data_o = flag_i;
      SEL_ENA:  rd_data_o = ena_i;
      SEL_CODE: rd_data_o = code_i;
      SEL_STAT: rd_data_o = stat_b;
      SEL_IE:   rd_data_o = ie_b;
      SEL_TEC:  rd_data_o = tec_i;
      SEL_REC:  rd_data_o = rec_i;
      default:  rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/canerr_irq_unit.sv
module canerr_irq_unit
  import canerr_pkg::*;
#(
  parameter int unsigned W   = BYTE_W,
  parameter int unsigned NEV = NUM_EVTS,
  parameter int unsigned NCD = NUM_CODES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NEV-1:0]   flag_evt_i,
  input  logic [NCD-1:0]   code_evt_i,
  input  logic [W-1:0]     tx_err_cnt_i,
  input  logic [W-1:0]     rx_err_cnt_i,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic [SEL_W-1:0] rd_sel_i,
  output logic [W-1:0]     rd_data_o,
  output logic [W-1:0]     flag_o,
  output logic [W-1:0]     code_o,
  output logic             irq_o
);
  logic         wr_flag, wr_ena, wr_code, wr_ie;
  logic [W-1:0] en_q, en_nxt;
  logic         ie_q, ie_nxt;
  logic         any_code;
  logic [W-1:0] flag_set;

  always_comb begin
    wr_flag = wr_en_i && (wr_sel_i == SEL_FLAG);
    wr_ena  = wr_en_i && (wr_sel_i == SEL_ENA);
    wr_code = wr_en_i && (wr_sel_i == SEL_CODE);
    wr_ie   = wr_en_i && (wr_sel_i == SEL_IE);
    en_nxt  = wr_data_i;
    ie_nxt  = wr_data_i[SUMMARY_B];
    flag_set = {flag_evt_i, any_code};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      en_q <= '0;
    else if (wr_ena) en_q <= en_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ie_q <= 1'b0;
    else if (wr_ie) ie_q <= ie_nxt;
  end

  canerr_flag_bank #(.WIDTH(W)) flags_u (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set),
    .clr_wr_i(wr_flag), .clr_data_i(wr_data_i), .flag_o(flag_o)
  );

  canerr_code_store #(.NCODE(NCD)) codes_u (
    .clk(clk), .rst_n(rst_n), .evt_i(code_evt_i),
    .wr_i(wr_code), .wdata_i(wr_data_i), .code_o(code_o),
    .any_evt_o(any_code)
  );

  canerr_irq_merge #(.W(W)) merge_u (
    .flag_i(flag_o), .ena_i(en_q), .code_i(code_o), .ie_i(ie_q),
    .tec_i(tx_err_cnt_i), .rec_i(rx_err_cnt_i), .rd_sel_i(rd_sel_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );
endmodule

// File: rtl/canerr_irq_chk.sv
module canerr_irq_chk
  import canerr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [6:0]       flag_evt_i,
  input logic [6:0]       code_evt_i,
  input logic             wr_en_i,
  input logic [SEL_W-1:0] wr_sel_i,
  input logic [7:0]       flag_o,
  input logic [7:0]       code_o,
  input logic [7:0]       en_q,
  input logic             ie_q,
  input logic             irq_o
);
  logic wr_flag_c, wr_code_c;
  assign wr_flag_c = wr_en_i && (wr_sel_i == SEL_FLAG);
  assign wr_code_c = wr_en_i && (wr_sel_i == SEL_CODE);

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_flag_c && flag_evt_i == '0 && code_evt_i == '0) |=> $stable(flag_o)); // R2

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_evt_i != '0) |=> ((flag_o[7:1] & $past(flag_evt_i)) == $past(flag_evt_i))); // R5

  AST_BUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (code_evt_i != '0) |=> flag_o[0]); // R3

  AST_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_o[7] && code_evt_i != '0) |=> (code_o[6:0] == $past(code_evt_i))); // R7

  AST_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
    (code_o[7] && !wr_code_c && code_evt_i != '0)
      |=> ((code_o[6:0] & $past(code_evt_i | code_o[6:0])) == $past(code_evt_i | code_o[6:0]))); // R6

  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ie_q); // R10

  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((flag_o & en_q) != '0)); // R9
endmodule

bind canerr_irq_unit canerr_irq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .flag_evt_i(flag_evt_i), .code_evt_i(code_evt_i),
  .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .flag_o(flag_o), .code_o(code_o),
  .en_q(en_q), .ie_q(ie_q), .irq_o(irq_o)
);

// File: tb/canerr_irq_unit_tb.sv
`timescale 1ns/1ps
module canerr_irq_unit_tb_top;
  logic       clk;
  logic       rst_n;
  logic [6:0] flag_evt, code_evt;
  logic [7:0] tec, rec;
  logic       wr_en;
  logic [2:0] wr_sel, rd_sel;
  logic [7:0] wr_data, rd_data, flag_o, code_o;
  logic       irq_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // behavioural model state
  byte unsigned m_flag, m_en, m_code;
  bit           m_ie;
  bit           model_live = 0;

  canerr_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .flag_evt_i(flag_evt), .code_evt_i(code_evt),
    .tx_err_cnt_i(tec), .rx_err_cnt_i(rec), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
    .flag_o(flag_o), .code_o(code_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic bit exp_irq();
    return ((m_flag & m_en) != 0) && m_ie;
  endfunction

  function automatic byte unsigned exp_rd(int sel);
    case (sel)
      0: return m_flag;
      1: return m_en;
      2: return m_code;
      3: return ((m_flag & m_en) != 0) ? 8'h20 : 8'h00;
      4: return m_ie ? 8'h20 : 8'h00;
      5: return tec;
      6: return rec;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // model update on the same edge the design samples
  always @(posedge clk) begin
    if (rst_n && model_live) begin
      byte unsigned keep;
      bit mode_old;
      mode_old = m_code[7];
      if (wr_en && wr_sel == 3'd0) m_flag = m_flag & wr_data;
      m_flag = m_flag | {flag_evt, (code_evt != 0)};
      if (wr_en && wr_sel == 3'd1) m_en = wr_data;
      if (wr_en && wr_sel == 3'd4) m_ie = wr_data[5];
      keep = m_code;
      if (wr_en && wr_sel == 3'd2) keep = {wr_data[7], m_code[6:0] & wr_data[6:0]};
      if (code_evt != 0) keep[6:0] = mode_old ? (keep[6:0] | code_evt) : code_evt;
      m_code = keep;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && model_live) begin
      chk("R2 R3 R4 R5 flag_o", flag_o, m_flag);
      chk("R6 R7 R8 code_o", code_o, m_code);
      chk("R9 R10 irq_o", irq_o, exp_irq());
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic idle();
    wr_en = 0; flag_evt = '0; code_evt = '0;
  endtask

  task automatic wr(input int sel, input byte unsigned d);
    wr_en = 1; wr_sel = sel[2:0]; wr_data = d;
    step(); idle();
  endtask

  task automatic rd_chk(input int sel, input string tag);
    rd_sel = sel[2:0]; #1;
    chk(tag, rd_data, exp_rd(sel));
  endtask

  initial begin
    int unsigned lfsr;
    rst_n = 0; idle(); wr_sel = 0; wr_data = 0; rd_sel = 0;
    tec = 8'h00; rec = 8'h00;
    m_flag = 0; m_en = 0; m_code = 0; m_ie = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 flag", flag_o, 0);
    chk("R1 code", code_o, 0);
    chk("R1 irq", irq_o, 0);
    for (int s = 0; s < 8; s++) if (s != 5 && s != 6) begin
      rd_sel = s[2:0]; #1; chk("R1 read", rd_data, 0);
    end
    #1 rst_n = 1; model_live = 1;
    step();

    // R12 enable load and R10 interrupt enable readback
    wr(1, 8'hFF); rd_chk(1, "R12 enable read");
    wr(4, 8'hFF); rd_chk(4, "R10 ie read only bit5");

    // R2 each event bit alone
    for (int k = 0; k < 7; k++) begin
      flag_evt = 7'(1 << k); step(); idle();
      step();
      chk("R2 flag bit set", flag_o[k+1], 1);
    end
    rd_chk(3, "R9 status summary");
    chk("R10 irq high", irq_o, 1);

    // R4 clear selected bits
    wr(0, 8'hFB); chk("R4 bit2 cleared", flag_o, 8'hFA);
    wr(0, 8'hFF); chk("R4 ones keep", flag_o, 8'hFA);
    wr(0, 8'h00); chk("R4 all cleared", flag_o, 8'h00);
    chk("R9 irq low no flags", irq_o, 0);

    // R5 event and clear in the same cycle
    flag_evt = 7'h10; wr(0, 8'h00);
    chk("R5 set wins", flag_o, 8'h20);
    wr(0, 8'h00);

    // R7 replace mode and R3 bus error flag
    code_evt = 7'h04; step(); idle();
    chk("R3 bus error flag", flag_o[0], 1);
    code_evt = 7'h10; step(); idle();
    chk("R7 replaced", code_o, 8'h10);
    // R5 on code: replace pulse with clear write
    code_evt = 7'h02; wr(2, 8'h00);
    chk("R5 code pulse beats clear", code_o, 8'h02);

    // R8 mode write, R6 accumulate
    wr(2, 8'h80); chk("R8 mode set codes cleared", code_o, 8'h80);
    code_evt = 7'h01; step(); idle();
    code_evt = 7'h08; step(); idle();
    chk("R6 accumulated", code_o, 8'h89);
    wr(2, 8'hF7); chk("R8 clear bit3 keep mode", code_o, 8'h81);

    // R10 gate off, R9 summary still set
    wr(4, 8'h00); chk("R10 irq gated", irq_o, 0);
    rd_chk(3, "R9 status with ie off");
    // R9 enable masking
    wr(0, 8'h00); wr(4, 8'h20); wr(1, 8'h01);
    flag_evt = 7'h40; step(); idle();
    rd_chk(3, "R9 masked flag no summary");
    chk("R9 masked irq low", irq_o, 0);

    // R11 counters, unused select, ignored writes
    tec = 8'hA5; rec = 8'h3C;
    rd_chk(5, "R11 tx count"); rd_chk(6, "R11 rx count"); rd_chk(7, "R11 sel7 zero");
    wr(3, 8'hFF); wr(5, 8'hFF); wr(6, 8'hFF); wr(7, 8'hFF);
    for (int s = 0; s < 5; s++) rd_chk(s, "R11 writes ignored");

    // mixed phase: pulses and writes together
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      flag_evt = (lfsr[3:0] == 0) ? lfsr[10:4] : 7'h0;
      code_evt = (lfsr[13:11] == 0) ? lfsr[20:14] : 7'h0;
      wr_en    = lfsr[22];
      wr_sel   = lfsr[25:23];
      wr_data  = lfsr[31:24] | (lfsr[26] ? 8'h00 : 8'h5A);
      rd_sel   = lfsr[29:27];
      step();
      rd_chk(int'(rd_sel), "R11 R12 mixed read");
    end
    idle(); step(); step();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule